// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block is an 8-bit general-purpose I/O port controller that sits on a simple processor register bus. Software configures each pin on its own through three registers: an output latch, a direction mask and an option mask. Each pin can be a floating input, a pull-up input that can raise an interrupt, an open-drain output or a push-pull output. For every pin the block drives three pad controls: the output value, the output enable and the pull-up enable.

Pad inputs pass through a two-flop synchroniser. The synchronised levels are returned on reads of the data register for pins that are inputs. They also feed a falling-edge detector, which sets per-pin pending interrupt bits. A fourth register exposes the pending bits and clears them when a 1 is written to them. A single request line reports whether any bit is pending. Some pins may be built without an option bit. Those pins take their configuration from the direction bit alone.

Top module: `gpio_port`

## Requirements
- R1: After reset the data, direction, option and pending registers all read 00h, and pad_oe, pad_pu and irq are 0. The register addresses are: 0 data, 1 direction, 2 option, 3 pending.
- R2: A direction bit of 0 makes its pin an input, with pad_oe low. A direction bit of 1 makes it an output.
- R3: A write to the data register updates the output latch for every bit, including bits whose pin is an input. A pin later switched to push-pull output drives the value that was written.
- R4: A read of address 0 returns, for each bit, the latch when that pin is an output and the synchronised pad level when it is an input. The synchronised level follows pad_in two rising clock edges after pad_in changes.
- R5: For an input pin, option 0 gives a floating pin (pad_pu 0) and option 1 turns on the pull-up (pad_pu 1). pad_pu is always 0 for an output pin.
- R6: For an output pin with option 1 (push-pull), pad_oe is 1 and pad_out equals the latch bit.
- R7: For an output pin with option 0 (open drain), pad_out is 0 and pad_oe is the inverse of the latch bit.
- R8: Pins with no option bit (bits 7 and 6 by default) read 0 at address 2, ignore writes there, and behave as if their option bit were 0.
- R9: A falling edge of the synchronised level on an input pin with option 1 sets that pin's pending bit. irq then rises three rising edges after the pad_in edge. A falling edge on a pin in any other configuration sets nothing.
- R10: Writing 1 to a bit at address 3 clears that pending bit, and writing 0 leaves it unchanged. irq is the OR of all pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| irq | output | 1 | OR of all pending interrupt bits |

## Verification
A register write takes effect at the rising edge where it is presented, so pad controls and read-back are checked at the next falling edge. Read data is combinational and is sampled 1 ns after the address is driven. A pad_in change reaches read-back after two rising edges and the pending bit after three. The bench therefore waits three full cycles after each pin change and probes irq at both the second and the third falling edge. Inputs are always driven on falling edges, well away from the active edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_OPT  = 2'd2,
    REG_PEND = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= d;
      stable_q <= meta_q;
    end
  end

  assign q = stable_q;

  // checker state: edges seen since reset release
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R4
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter logic [W-1:0] OPT_IMPL  = '1,
  parameter logic [W-1:0] OPT_FIXED = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pin_lvl,
  input  logic [W-1:0]      pend,
  output logic [W-1:0]      latch_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      opt_o,
  output logic [W-1:0]      clr_o
);
  localparam logic [W-1:0] OPT_CONST = OPT_FIXED & ~OPT_IMPL;

  gpio_reg_e    reg_sel;
  logic         wr_en;
  logic [W-1:0] latch_q, latch_d;
  logic [W-1:0] dir_q,   dir_d;
  logic [W-1:0] opt_q,   opt_d;

  assign reg_sel = gpio_reg_e'(addr);
  assign wr_en   = sel & wr;

  always_comb begin
    latch_d = latch_q;
    dir_d   = dir_q;
    opt_d   = opt_q;
    clr_o   = '0;
    if (wr_en) begin
      unique case (reg_sel)
        REG_DATA: latch_d = wdata;
        REG_DIR:  dir_d   = wdata;
        REG_OPT:  opt_d   = (wdata & OPT_IMPL) | OPT_CONST;
        REG_PEND: clr_o   = wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      opt_q   <= OPT_CONST;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
      opt_q   <= opt_d;
    end
  end

  always_comb begin
    unique case (reg_sel)
      REG_DATA: rdata = (dir_q & latch_q) | (~dir_q & pin_lvl);
      REG_DIR:  rdata = dir_q;
      REG_OPT:  rdata = opt_q;
      REG_PEND: rdata = pend;
    endcase
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
  assign opt_o   = opt_q;

  // R3
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == REG_DATA) |=> (latch_q == $past(wdata)));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] opt,
  input  logic [W-1:0] latch,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] irq_en
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      pad_out[i] = 1'b0;
      pad_oe[i]  = 1'b0;
      pad_pu[i]  = 1'b0;
      irq_en[i]  = 1'b0;
      if (dir[i]) begin
        if (opt[i]) begin
          pad_oe[i]  = 1'b1;
          pad_out[i] = latch[i];
        end else begin
          pad_oe[i]  = ~latch[i];
        end
      end else begin
        pad_pu[i] = opt[i];
        irq_en[i] = opt[i];
      end
    end
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q, pend_q, pend_d, fall;

  assign fall = prev_q & ~lvl & en;

  always_comb begin
    pend_d = (pend_q & ~clr) | fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R9
    pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(en[i] && !lvl[i]));
    // R10
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !fall[i]) |=> !pend_q[i]);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter logic [W-1:0] OPT_IMPL  = 8'h3F,
  parameter logic [W-1:0] OPT_FIXED = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pu,
  output logic              irq
);
  logic         rst_sync_n;
  logic [W-1:0] pin_lvl, pend, latch, dir, opt, clr, irq_en;

  gpio_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n));

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pad_in), .q(pin_lvl)
  );

  gpio_regs #(.W(W), .OPT_IMPL(OPT_IMPL), .OPT_FIXED(OPT_FIXED)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .sel(bus_sel), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .pin_lvl(pin_lvl), .pend(pend), .latch_o(latch), .dir_o(dir),
    .opt_o(opt), .clr_o(clr)
  );

  gpio_pad_ctl #(.W(W)) u_pad (
    .dir(dir), .opt(opt), .latch(latch),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq_en(irq_en)
  );

  gpio_irq #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .lvl(pin_lvl), .en(irq_en),
    .clr(clr), .pend(pend)
  );

  assign irq = |pend;

  // R2
  dir_input_oe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && bus_wr && bus_addr == REG_DIR)
      |=> ((pad_oe & ~$past(bus_wdata)) == '0));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pad_pu;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [7:0] IMPL = 8'h3F;

  always #4 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(2'd0, rv); chk("R1 data", rv, 8'h00);
    rd_reg(2'd1, rv); chk("R1 dir", rv, 8'h00);
    rd_reg(2'd2, rv); chk("R1 opt", rv, 8'h00);
    rd_reg(2'd3, rv); chk("R1 pend", rv, 8'h00);
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 pu", pad_pu, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R3 latch written while input, then shown on switch to push-pull
    wr_reg(2'd0, 8'hA5);
    chk("R3 oe while input", pad_oe, 8'h00);
    wr_reg(2'd2, 8'hFF);
    wr_reg(2'd1, 8'hFF);
    chk("R3 out after switch", pad_out & IMPL, 8'hA5 & IMPL);
    chk("R3 oe after switch", pad_oe, IMPL | (8'hC0 & ~8'hA5));

    // R8 unimplemented option bits
    rd_reg(2'd2, rv); chk("R8 opt read", rv, IMPL);

    // R4 sync latency: pin change visible after two edges
    wr_reg(2'd1, 8'h00);
    pad_in = 8'h5C;
    @(negedge clk);
    rd_reg(2'd0, rv); chk("R4 one edge", rv, 8'h00);
    @(negedge clk);
    rd_reg(2'd0, rv); chk("R4 two edges", rv, 8'h5C);

    // R2 R4 R5 R6 R7 R8 sweep over all direction patterns
    for (int k = 0; k < 256; k++) begin
      logic [7:0] d, o, l, p, oe_e, out_e, pu_e, rd_e, oe_f;
      d = 8'(k);
      o = 8'(k * 37 + 11);
      l = 8'(k * 91 + 5);
      p = 8'(k) ^ 8'h3C;
      wr_reg(2'd0, l);
      wr_reg(2'd2, o);
      wr_reg(2'd1, d);
      pad_in = p;
      repeat (3) @(negedge clk);
      oe_f  = o & IMPL;
      oe_e  = d & (oe_f | ~l);
      out_e = d & oe_f & l;
      pu_e  = ~d & oe_f;
      rd_e  = (d & l) | (~d & p);
      chk("R2 R6 R7 oe", pad_oe, oe_e);
      chk("R6 R7 out", pad_out, out_e);
      chk("R5 pu", pad_pu, pu_e);
      rd_reg(2'd0, rv); chk("R4 readback", rv, rd_e);
      rd_reg(2'd2, rv); chk("R8 opt", rv, oe_f);
    end

    // R9 interrupt on falling edge of enabled input
    wr_reg(2'd1, 8'h02);
    wr_reg(2'd2, 8'h3F);
    pad_in = 8'hFF;
    repeat (4) @(negedge clk);
    wr_reg(2'd3, 8'hFF);
    rd_reg(2'd3, rv); chk("R10 cleared", rv, 8'h00);
    chk("R10 irq low", {7'd0, irq}, 8'h00);
    pad_in = 8'h7C;   // bit0 enabled, bit1 output, bit7 no option
    @(negedge clk);
    @(negedge clk);
    chk("R9 not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R9 irq", {7'd0, irq}, 8'h01);
    rd_reg(2'd3, rv); chk("R9 pend", rv, 8'h01);

    // R10 write 0 keeps, write 1 clears
    wr_reg(2'd3, 8'hFE);
    rd_reg(2'd3, rv); chk("R10 zero keeps", rv, 8'h01);
    wr_reg(2'd3, 8'h01);
    rd_reg(2'd3, rv); chk("R10 one clears", rv, 8'h00);
    chk("R10 irq cleared", {7'd0, irq}, 8'h00);

    // R9 floating input does not interrupt
    wr_reg(2'd2, 8'h00);
    pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    rd_reg(2'd3, rv); chk("R9 floating no pend", rv, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule